// File: doc/BRIEF.md
# Correlating Two-Level Branch Predictor

This block predicts the direction of conditional branches. It keeps a table of small saturating counters organised as rows and columns. The row is picked by low bits of the branch address. The column is picked by a global history register that records the outcomes of the most recent branches. A counter therefore learns how one branch behaves after one particular pattern of earlier outcomes, so branches whose direction follows their neighbours' can be predicted well.

A fetch stage presents an address with a valid strobe and reads the prediction in the same cycle. When the branch resolves, an update carries the branch address and its real outcome. That update moves the selected counter one step toward the outcome and shifts the outcome into the history.

The parameters are the history length `HIST_BITS`, the counter width `CTR_BITS`, the number of address rows `ROWS` and the lowest address bit used for the row, `IDX_LSB`. Their defaults give a (2,2) predictor with 16 rows. The storage is `ROWS * 2^HIST_BITS * CTR_BITS` flops, which is 128 at the defaults.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset, every counter is 0 and the history is all zeros, so every lookup predicts not taken.
- R2: `pred_taken` is 0 whenever `lk_valid` is 0.
- R3: With `lk_valid` at 1, `pred_taken` is 1 exactly when the selected counter is at least 2^(CTR_BITS-1). The selected counter is the one at row `lk_addr[IDX_LSB +: log2(ROWS)]` and column equal to the current history value. The result is combinational in the same cycle.
- R4: An update with `up_taken`=1 increments the selected counter, saturating at 2^CTR_BITS-1. An update with `up_taken`=0 decrements it, saturating at 0.
- R5: With 2-bit counters, a counter at either extreme needs two consecutive opposite outcomes before its prediction changes. A single opposite outcome leaves the prediction unchanged.
- R6: Each update shifts the history left by one, with the new outcome entering bit 0 and the oldest bit falling out. Without an update the history holds its value.
- R7: An update changes only the counter at row `up_addr[IDX_LSB +: log2(ROWS)]` and at the column equal to the history value before that update's shift.
- R8: When a lookup and an update happen in the same cycle, the lookup sees the state from before the update. The update takes effect at the next clock edge.
- R9: One branch address reached under different history values uses separate counters, so it can be predicted differently.
- R10: With CTR_BITS=1, the prediction for a given row and history equals the last outcome recorded there.
- R11: Address bits above the row field and below `IDX_LSB` play no part in the lookup, so such addresses alias to the same counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup address is valid |
| lk_addr | input | ADDR_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
On every cycle, the assertions check that the prediction is quiet when no lookup is valid. They check that each update moves exactly one counter by one saturating step and leaves every other counter alone. They also check that the history takes the new outcome in its low bit and otherwise holds. Some behaviours involve the whole sequence: the two-miss hysteresis, the separate counters chosen by history at one address, aliasing of address bits, same-cycle lookup/update ordering and the 1-bit last-outcome mode. Only the bench's directed scenarios can show these, by comparing observed predictions with independently computed values.

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor #(
  parameter int ADDR_W    = 32,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  parameter int ROWS      = 16,
  parameter int IDX_LSB   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              pred_taken,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken
);
  localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COLS    = 1 << HIST_BITS;
  localparam int ENTRIES = ROWS * COLS;
  localparam int IDX_W   = ROW_W + HIST_BITS;
  localparam logic [CTR_BITS-1:0] CTR_MAX = {CTR_BITS{1'b1}};

  logic [HIST_BITS-1:0] ghr_q;
  logic [CTR_BITS-1:0]  ctr_q [ENTRIES];

  logic [IDX_W-1:0]    lk_idx, up_idx;
  logic [CTR_BITS-1:0] lk_ctr, up_ctr, up_next;
  logic                unused_bits;

  assign lk_idx = {lk_addr[IDX_LSB +: ROW_W], ghr_q};
  assign up_idx = {up_addr[IDX_LSB +: ROW_W], ghr_q};
  assign lk_ctr = ctr_q[lk_idx];
  assign up_ctr = ctr_q[up_idx];
  assign unused_bits = ^{lk_addr, up_addr};

  assign pred_taken = lk_valid & lk_ctr[CTR_BITS-1];

  always_comb begin
    if (up_taken)
      up_next = (up_ctr == CTR_MAX) ? up_ctr : up_ctr + 1'b1;
    else
      up_next = (up_ctr == '0) ? up_ctr : up_ctr - 1'b1;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ctr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctr_q[e] <= '0;
      else if (up_valid && (up_idx == IDX_W'(e)))
        ctr_q[e] <= up_next;
    end
  end

  if (HIST_BITS == 1) begin : g_hist1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ghr_q <= '0;
      else if (up_valid)
        ghr_q <= up_taken;
    end
  end else begin : g_histn
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ghr_q <= '0;
      else if (up_valid)
        ghr_q <= {ghr_q[HIST_BITS-2:0], up_taken};
    end
  end
endmodule

// File: rtl/corr_branch_predictor_chk.sv
module corr_branch_predictor_chk #(
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  parameter int ENTRIES   = 64,
  parameter int IDX_W     = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lk_valid,
  input logic                 pred_taken,
  input logic                 up_valid,
  input logic                 up_taken,
  input logic [IDX_W-1:0]     up_idx,
  input logic [HIST_BITS-1:0] ghr,
  input logic [CTR_BITS-1:0]  tbl [ENTRIES]
);
  localparam logic [CTR_BITS-1:0] TOP = {CTR_BITS{1'b1}};

  logic                prev_up, prev_tk, seen_low, done;
  logic [IDX_W-1:0]    prev_idx;
  logic [CTR_BITS-1:0] prev_tbl [ENTRIES];
  logic [CTR_BITS-1:0] old_val, want_inc, want_dec;
  logic                others_ok, all_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_up  <= 1'b0;
      prev_tk  <= 1'b0;
      prev_idx <= '0;
      seen_low <= 1'b1;
      done     <= 1'b0;
    end else begin
      prev_up  <= up_valid;
      prev_tk  <= up_taken;
      prev_idx <= up_idx;
      seen_low <= seen_low;
      done     <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) prev_tbl[i] <= tbl[i];
  end

  always_comb begin
    old_val  = prev_tbl[prev_idx];
    want_inc = (old_val == TOP) ? TOP : old_val + 1'b1;
    want_dec = (old_val == '0) ? old_val : old_val - 1'b1;
    others_ok = 1'b1;
    all_zero  = 1'b1;
    for (int i = 0; i < ENTRIES; i++) begin
      if (tbl[i] != '0) all_zero = 1'b0;
      if (!(prev_up && (prev_idx == IDX_W'(i))) && (tbl[i] != prev_tbl[i]))
        others_ok = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (rst_n && (seen_low === 1'b1) && (done === 1'b0))
      assert_reset_state_R1: assert (ghr == '0 && all_zero)
        else $error("reset state wrong");
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !pred_taken);

  assert_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_up && prev_tk) |-> (tbl[prev_idx] == want_inc));

  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_up && !prev_tk) |-> (tbl[prev_idx] == want_dec));

  assert_newest_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (ghr[0] == $past(up_taken)));

  assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghr));

  assert_single_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> others_ok);
endmodule

bind corr_branch_predictor corr_branch_predictor_chk #(
  .HIST_BITS(HIST_BITS), .CTR_BITS(CTR_BITS), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .pred_taken(pred_taken),
  .up_valid(up_valid), .up_taken(up_taken), .up_idx(up_idx),
  .ghr(ghr_q), .tbl(ctr_q)
);

// File: tb/corr_branch_predictor_bench.sv
`timescale 1ns/1ps
module corr_branch_predictor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        up_valid = 1'b0;
  logic [31:0] up_addr = '0;
  logic        up_taken = 1'b0;
  logic        pred_taken, pred_one;

  int total = 0;
  int bad = 0;
  int mc2 [64];
  int mc1 [64];
  int mh = 0;

  localparam logic [31:0] A = 32'h100;
  localparam logic [31:0] B = 32'h104;
  localparam logic [31:0] C = 32'h208;

  always #2.5 clk = ~clk;

  corr_branch_predictor u_corr_branch_predictor (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .pred_taken(pred_taken), .up_valid(up_valid), .up_addr(up_addr),
    .up_taken(up_taken));

  corr_branch_predictor #(.CTR_BITS(1)) u_one (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .pred_taken(pred_one), .up_valid(up_valid), .up_addr(up_addr),
    .up_taken(up_taken));

  function automatic int ridx(logic [31:0] a);
    return int'((a >> 2) & 32'd15) * 4 + mh;
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic model_apply(input logic [31:0] a, input logic t);
    int i;
    i = ridx(a);
    if (t) mc2[i] = (mc2[i] == 3) ? 3 : mc2[i] + 1;
    else   mc2[i] = (mc2[i] == 0) ? 0 : mc2[i] - 1;
    mc1[i] = t ? 1 : 0;
    mh = ((mh << 1) | (t ? 1 : 0)) & 3;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lk_valid = 1'b0; up_valid = 1'b0;
    for (int i = 0; i < 64; i++) begin mc2[i] = 0; mc1[i] = 0; end
    mh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic upd(input logic [31:0] a, input logic t);
    @(negedge clk);
    up_valid = 1'b1; up_addr = a; up_taken = t;
    @(negedge clk);
    up_valid = 1'b0;
    model_apply(a, t);
  endtask

  task automatic look(input logic [31:0] a, input string tag);
    lk_valid = 1'b1; lk_addr = a; #1;
    chk(pred_taken, mc2[ridx(a)] >= 2, tag);
    chk(pred_one, mc1[ridx(a)] == 1, "R10 one-bit model");
  endtask

  task automatic expect_pred(input logic [31:0] a, input logic e, input string tag);
    lk_valid = 1'b1; lk_addr = a; #1;
    chk(pred_taken, e, tag);
  endtask

  task automatic t_reset();
    do_reset();
    for (int k = 0; k < 4; k++) expect_pred(A + 32'(k * 36), 1'b0, "R1 reset not taken");
    lk_valid = 1'b0; #1;
    chk(pred_taken, 1'b0, "R2 idle after reset");
  endtask

  task automatic t_hysteresis();
    do_reset();
    upd(A, 1); upd(A, 1); upd(A, 1);
    expect_pred(A, 1'b0, "R5 one miss no flip");
    upd(A, 1);
    expect_pred(A, 1'b1, "R5 second miss flips");
    upd(A, 1); upd(A, 1);
    upd(A, 0);
    upd(B, 1); upd(B, 1);
    expect_pred(A, 1'b1, "R5 single not-taken keeps taken");
    lk_valid = 1'b1; lk_addr = A; #1;
    chk(pred_one, 1'b0, "R10 one-bit follows last outcome");
    look(A, "R3 model after hysteresis");
  endtask

  task automatic t_floor();
    do_reset();
    upd(A, 0); upd(A, 0); upd(A, 0);
    expect_pred(A, 1'b0, "R4 floor");
    upd(A, 1);
    upd(B, 0); upd(B, 0);
    expect_pred(A, 1'b0, "R4 no underflow wrap");
    look(A, "R3 model at floor");
    upd(A, 1);
    upd(B, 0); upd(B, 0);
    expect_pred(A, 1'b1, "R4 climbs to taken");
    lk_valid = 1'b1; lk_addr = A; #1;
    chk(pred_one, 1'b1, "R10 one-bit after taken");
  endtask

  task automatic t_correlation();
    do_reset();
    upd(B, 1); upd(B, 1);
    upd(C, 1); upd(C, 1);
    upd(B, 0); upd(B, 0);
    expect_pred(C, 1'b0, "R9 history 00 column untrained");
    expect_pred(B, 1'b0, "R7 B column 00 decremented only");
    upd(B, 1); upd(B, 1);
    expect_pred(C, 1'b1, "R9 history 11 column taken");
    expect_pred(C + 32'h40, 1'b1, "R11 high bits alias");
    expect_pred(C + 32'h3, 1'b1, "R11 low bits alias");
    expect_pred(C + 32'h4, 1'b0, "R7 neighbour row untouched");
    lk_valid = 1'b0; #1;
    chk(pred_taken, 1'b0, "R2 idle masks taken counter");
    look(C, "R6 history model");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = C;
    up_valid = 1'b1; up_addr = C; up_taken = 1'b0;
    #1;
    chk(pred_taken, 1'b1, "R8 lookup sees old state");
    @(negedge clk);
    up_valid = 1'b0;
    model_apply(C, 1'b0);
    upd(B, 1); upd(B, 1);
    expect_pred(C, 1'b0, "R8 update applied after edge");
  endtask

  task automatic t_mixed();
    do_reset();
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      logic t;
      a = 32'h1000 + 32'((i * 5) % 7) * 4;
      t = ((i * 7) % 3) != 0;
      upd(a, t);
      look(a, "R3 mixed pattern");
      look(a + 32'h40, "R11 mixed alias");
    end
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_hysteresis();
    t_floor();
    t_correlation();
    t_same_cycle();
    t_mixed();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule